// File: doc/BRIEF.md
# SPI Byte FIFO Controller

This block holds the two byte queues that sit between a processor bus and a serial shifter. Processor writes go into a transmit queue, and the shifter takes bytes from the head of that queue. Bytes the shifter assembles go into a receive queue, and processor reads take them from its head. Both sides use simple one-cycle strobes. The shifter is told a byte is waiting as soon as the transmit queue is not empty, so a master-mode transfer can start right after the processor's first load.

The receive side raises an interrupt request when its fill level reaches one of four selectable trigger points. A byte that arrives while the receive queue has no room is dropped, and a sticky overrun flag records the loss. A processor write is refused while the transmit queue is full. It is accepted again in the cycle the shifter takes a byte. Queue depth is a parameter (64, 128, 256 or 512).

Top module: `spi_fifo_ctrl`

## Requirements
- R1: After reset both queues are empty, both counts are 0, and `rx_irq` and `rx_overrun` are 0.
- R2: The transmit queue presents bytes on `sh_tx_data` in write order. `sh_tx_valid` is 1 whenever `tx_count` is non-zero, starting in the cycle after the first write.
- R3: While `tx_count` equals DEPTH and `sh_tx_ready` is 0, `cpu_wr_ready` is 0. A write attempted then is ignored: the count and the stored bytes are unchanged.
- R4: A processor write in the same cycle that the shifter takes a byte is accepted even when the transmit queue is full, and `tx_count` stays the same.
- R5: The receive queue presents bytes on `cpu_rd_data` in arrival order. A `cpu_rd_req` on a non-empty queue removes the head byte.
- R6: A byte arriving on `sh_rx_valid` while `rx_count` equals DEPTH and no read happens is not stored, and `rx_overrun` is 1 from the next cycle.
- R7: `rx_overrun` stays 1 until a cycle with `ovr_clr` high and no new overrun. A new overrun wins over a clear in the same cycle.
- R8: The trigger level is chosen by `trig_sel`: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2 and 3 gives DEPTH-2. With `irq_en` high, `rx_irq` is 1 exactly while `rx_count` is at or above that level.
- R9: With `irq_en` low, `rx_irq` is 0 whatever the count.
- R10: A receive push and a read in the same cycle at a full queue leave `rx_count` at DEPTH and raise no overrun. A read of an empty queue leaves `rx_count` at 0.
- R11: `tx_count` and `rx_count` rise by one for each accepted push and fall by one for each accepted pop, one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_valid | input | 1 | Processor write strobe into the transmit queue |
| cpu_wr_data | input | DW | Byte to transmit |
| cpu_wr_ready | output | 1 | Write will be accepted this cycle |
| cpu_rd_req | input | 1 | Processor read strobe from the receive queue |
| cpu_rd_data | output | DW | Head byte of the receive queue |
| sh_tx_valid | output | 1 | Transmit queue holds a byte |
| sh_tx_data | output | DW | Head byte of the transmit queue |
| sh_tx_ready | input | 1 | Shifter takes the head byte this cycle |
| sh_rx_valid | input | 1 | Shifter delivers a received byte |
| sh_rx_data | input | DW | Received byte |
| irq_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Receive trigger level select |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| tx_count | output | $clog2(DEPTH)+1 | Transmit fill level |
| rx_count | output | $clog2(DEPTH)+1 | Receive fill level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_irq | output | 1 | Receive trigger interrupt request |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
Counts, full/empty flags, head data and the overrun flag change one cycle after the strobe that causes them. So the bench drives each strobe, waits one rising edge, and samples shortly after that edge. `cpu_wr_ready`, `sh_tx_valid` and `rx_irq` are combinational from registered state and from the current inputs. The bench checks them after changing an input and before the next edge. This includes a check at every receive count from 0 to DEPTH for all four trigger settings. Head data is compared just before the edge that pops it, against a sequence the bench computes itself.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    typedef enum logic [1:0] {
        TRIG_ONE     = 2'd0,
        TRIG_QUARTER = 2'd1,
        TRIG_HALF    = 2'd2,
        TRIG_NEAR    = 2'd3
    } trig_sel_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];

    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rd];

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop_req && !empty;
        push_ok = push_req && (!full || pop_ok);
        if (push_ok) st_d.wr = st_q.wr + 1'b1;
        if (pop_ok)  st_d.rd = st_q.rd + 1'b1;
        if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= push_data;
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full && push_req && !pop_req |=> full);
    p_empty_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop_req && !push_req |=> empty);
endmodule

// File: rtl/rx_trigger.sv
module rx_trigger #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [1:0]    sel,
    input  logic          en,
    output logic          irq
);
    import spi_fifo_pkg::*;

    localparam logic [CW-1:0] LV_ONE  = CW'(1);
    localparam logic [CW-1:0] LV_QTR  = CW'(DEPTH / 4);
    localparam logic [CW-1:0] LV_HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LV_NEAR = CW'(DEPTH - 2);

    logic [CW-1:0] level;

    always_comb begin
        case (trig_sel_e'(sel))
            TRIG_ONE:     level = LV_ONE;
            TRIG_QUARTER: level = LV_QTR;
            TRIG_HALF:    level = LV_HALF;
            default:      level = LV_NEAR;
        endcase
        irq = en && (count >= level);
    end

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);
    p_irq_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count == '0 |-> !irq);
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_valid,
    input  logic [DW-1:0] cpu_wr_data,
    output logic          cpu_wr_ready,
    input  logic          cpu_rd_req,
    output logic [DW-1:0] cpu_rd_data,
    output logic          sh_tx_valid,
    output logic [DW-1:0] sh_tx_data,
    input  logic          sh_tx_ready,
    input  logic          sh_rx_valid,
    input  logic [DW-1:0] sh_rx_data,
    input  logic          irq_en,
    input  logic [1:0]    trig_sel,
    input  logic          ovr_clr,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          rx_irq,
    output logic          rx_overrun
);
    typedef struct packed {
        logic ovr;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok, rx_drop;

    byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .push_req(cpu_wr_valid), .push_data(cpu_wr_data),
        .pop_req(sh_tx_ready),
        .head(sh_tx_data), .count(tx_count),
        .full(tx_full), .empty(tx_empty),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push_req(sh_rx_valid), .push_data(sh_rx_data),
        .pop_req(cpu_rd_req),
        .head(cpu_rd_data), .count(rx_count),
        .full(rx_full), .empty(rx_empty),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    rx_trigger #(.DEPTH(DEPTH)) u_trig (
        .clk(clk), .rst_n(rst_n),
        .count(rx_count), .sel(trig_sel), .en(irq_en), .irq(rx_irq)
    );

    assign sh_tx_valid  = !tx_empty;
    assign cpu_wr_ready = !tx_full || tx_pop_ok;
    assign rx_drop      = sh_rx_valid && !rx_push_ok;
    assign rx_overrun   = ctl_q.ovr;

    always_comb begin
        ctl_d = ctl_q;
        if (ovr_clr) ctl_d.ovr = 1'b0;
        if (rx_drop) ctl_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    p_tx_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count != '0) |-> sh_tx_valid);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && !sh_tx_ready |-> !cpu_wr_ready);
    p_refused_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_valid && !cpu_wr_ready |=> $stable(tx_count));
    p_tx_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_ok && !tx_pop_ok |=> tx_count == $past(tx_count) + 1'b1);
    p_rx_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_ok && !rx_push_ok |=> rx_count == $past(rx_count) - 1'b1);
    p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sh_rx_valid && rx_full && !cpu_rd_req |=> rx_overrun);
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun && !ovr_clr |=> rx_overrun);
    p_swap_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && sh_rx_valid && cpu_rd_req |=> rx_full);
endmodule

// File: tb/spi_fifo_ctrl_test.sv
module spi_fifo_ctrl_test;
    localparam int DW = 8;
    localparam int DEPTH = 64;
    localparam int CW = $clog2(DEPTH) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_wr_valid = 0, cpu_rd_req = 0, sh_tx_ready = 0, sh_rx_valid = 0;
    logic irq_en = 0, ovr_clr = 0;
    logic [1:0] trig_sel = 0;
    logic [DW-1:0] cpu_wr_data = 0, sh_rx_data = 0;
    logic cpu_wr_ready, sh_tx_valid, tx_full, tx_empty, rx_full, rx_empty, rx_irq, rx_overrun;
    logic [DW-1:0] cpu_rd_data, sh_tx_data;
    logic [CW-1:0] tx_count, rx_count;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
        cpu_wr_valid = 0; cpu_rd_req = 0; sh_tx_ready = 0; sh_rx_valid = 0; ovr_clr = 0;
    endtask

    function automatic int lvl(input int s);
        case (s)
            0: return 1;
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            default: return DEPTH - 2;
        endcase
    endfunction

    function automatic logic [7:0] txb(input int i);
        return 8'((i * 3 + 7) % 256);
    endfunction

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step; step;
        rst_n = 1;
        step;
        // R1 reset state
        chk(tx_empty && rx_empty, "R1 empty", {tx_empty, rx_empty}, 3);
        chk(tx_count == 0 && rx_count == 0, "R1 counts", tx_count + rx_count, 0);
        chk(!rx_irq && !rx_overrun, "R1 flags", {rx_irq, rx_overrun}, 0);

        // Fill the transmit queue with the shifter idle
        for (int i = 0; i < DEPTH; i++) begin
            chk(cpu_wr_ready == 1, "R3 ready below full", cpu_wr_ready, 1);
            cpu_wr_valid = 1; cpu_wr_data = txb(i);
            step;
            chk(tx_count == i + 1, "R11 tx count", tx_count, i + 1);
            if (i == 0) begin
                chk(sh_tx_valid == 1, "R2 valid after first load", sh_tx_valid, 1);
                chk(sh_tx_data == txb(0), "R2 head", sh_tx_data, txb(0));
            end
        end
        chk(tx_full == 1, "R3 full", tx_full, 1);
        chk(cpu_wr_ready == 0, "R3 ready low", cpu_wr_ready, 0);
        cpu_wr_valid = 1; cpu_wr_data = 8'hEE;
        step;
        chk(tx_count == DEPTH, "R3 refused write count", tx_count, DEPTH);
        chk(sh_tx_data == txb(0), "R3 head kept", sh_tx_data, txb(0));

        // R4 write together with shift at full
        cpu_wr_valid = 1; cpu_wr_data = 8'hAA; sh_tx_ready = 1;
        #0;
        chk(cpu_wr_ready == 1, "R4 ready with shift", cpu_wr_ready, 1);
        step;
        chk(tx_count == DEPTH, "R4 count held", tx_count, DEPTH);

        // Drain and check order (R2, R3 no corruption)
        for (int i = 1; i <= DEPTH; i++) begin
            automatic int e = (i == DEPTH) ? 8'hAA : txb(i);
            chk(sh_tx_data == e, "R2 order", sh_tx_data, e);
            sh_tx_ready = 1;
            step;
        end
        chk(tx_empty && !sh_tx_valid, "R2 valid low when empty", sh_tx_valid, 0);
        chk(tx_count == 0, "R11 tx drained", tx_count, 0);

        // Receive fill with trigger sweep
        for (int k = 0; k <= DEPTH; k++) begin
            for (int s = 0; s < 4; s++) begin
                irq_en = 1; trig_sel = 2'(s);
                #0.5;
                chk(rx_irq == (k >= lvl(s)), "R8 trigger", rx_irq, k >= lvl(s));
            end
            irq_en = 0;
            #0.5;
            chk(rx_irq == 0, "R9 irq disabled", rx_irq, 0);
            chk(rx_count == k, "R11 rx count", rx_count, k);
            if (k < DEPTH) begin
                sh_rx_valid = 1; sh_rx_data = 8'(8'hC0 ^ k);
                step;
            end
        end
        chk(rx_full == 1 && rx_overrun == 0, "R6 full no overrun yet", rx_overrun, 0);

        // R6 overrun
        sh_rx_valid = 1; sh_rx_data = 8'h55;
        step;
        chk(rx_overrun == 1, "R6 overrun set", rx_overrun, 1);
        chk(rx_count == DEPTH, "R6 byte dropped", rx_count, DEPTH);
        step;
        chk(rx_overrun == 1, "R7 sticky", rx_overrun, 1);
        ovr_clr = 1;
        step;
        chk(rx_overrun == 0, "R7 cleared", rx_overrun, 0);

        // R10 push and read together at full
        chk(cpu_rd_data == 8'hC0, "R5 head", cpu_rd_data, 8'hC0);
        sh_rx_valid = 1; sh_rx_data = 8'h99; cpu_rd_req = 1;
        step;
        chk(rx_count == DEPTH, "R10 count held", rx_count, DEPTH);
        chk(rx_overrun == 0, "R10 no overrun", rx_overrun, 0);

        // R7 set wins over clear
        sh_rx_valid = 1; sh_rx_data = 8'h33; ovr_clr = 1;
        step;
        chk(rx_overrun == 1, "R7 set over clear", rx_overrun, 1);
        ovr_clr = 1;
        step;

        // R5 drain order
        for (int i = 1; i <= DEPTH; i++) begin
            automatic int e = (i == DEPTH) ? 8'h99 : (8'hC0 ^ i);
            chk(cpu_rd_data == e, "R5 order", cpu_rd_data, e);
            cpu_rd_req = 1;
            step;
        end
        chk(rx_empty == 1 && rx_count == 0, "R5 drained", rx_count, 0);
        cpu_rd_req = 1;
        step;
        chk(rx_count == 0 && rx_empty == 1, "R10 read empty", rx_count, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule